// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block steers a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Every cycle it looks at the register numbers, valid flags, write enables and load markers held in the pipeline registers, plus the branch-redirect signal produced in execute. From these it decides where each execute-stage operand comes from, whether fetch and decode must freeze, whether a no-op must enter execute, and which younger stages must be squashed. The outputs are combinational, so the surrounding pipeline registers act on them at the next clock edge.

Values computed in execute and sitting in the execute/memory register, and values in the memory/writeback register, can be routed back to the execute operand inputs. A loaded value is not ready until the memory access has completed, so a load immediately followed by a reader costs one bubble. Any other read-after-write case is bypassed at no cost. Branches resolve in execute, so a redirect discards the two younger instructions and costs two cycles. The unit assumes separate instruction and data memories, so there are no shared-port conflicts. It also assumes a register file whose write becomes visible to the next read.

Top module: `hzd_unit`

## Requirements
- R1: When no hazard is present, all stall and flush outputs stay low, so a sequence of N instructions reaches writeback N+3 cycles after reset is released.
- R2: An execute-stage source equal to the destination of a valid, write-enabled memory-stage instruction gives select value 1 (memory-stage result) on its bypass select.
- R3: An execute-stage source that matches only a valid, write-enabled writeback-stage destination gives select value 2 (writeback result).
- R4: When both the memory-stage and the writeback-stage destinations match a source, the memory-stage result (select 1) wins.
- R5: Register 0, a cleared write enable, an invalid stage or an operand that is not used never produce a bypass (select 0 means register file) and never cause a stall.
- R6: A valid, write-enabled load in execute whose nonzero destination is read by the decode-stage instruction raises pc_hold, fd_hold and de_bubble for exactly one cycle, which adds one cycle per such pair.
- R7: A redirect from execute raises both fd_flush and de_flush, which adds two cycles per redirecting branch.
- R8: When a redirect and a load-use condition occur in the same cycle, only the flush outputs are raised, and pc_hold, fd_hold and de_bubble stay low.
- R9: While reset is held with idle inputs, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src1 | input | REG_AW | First source register of the decode-stage instruction |
| dec_src2 | input | REG_AW | Second source register of the decode-stage instruction |
| dec_use1 | input | 1 | Decode instruction reads its first source |
| dec_use2 | input | 1 | Decode instruction reads its second source |
| exe_src1 | input | REG_AW | First source register of the execute-stage instruction |
| exe_src2 | input | REG_AW | Second source register of the execute-stage instruction |
| exe_use1 | input | 1 | Execute instruction reads its first source |
| exe_use2 | input | 1 | Execute instruction reads its second source |
| exe_dst | input | REG_AW | Destination register in execute |
| exe_wen | input | 1 | Execute instruction writes a register |
| exe_load | input | 1 | Execute instruction is a load |
| exe_valid | input | 1 | Execute stage holds a real instruction |
| mem_dst | input | REG_AW | Destination register in the memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| wb_dst | input | REG_AW | Destination register in writeback |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| exe_redirect | input | 1 | Taken or mispredicted branch resolved in execute |
| byp_sel1 | output | 2 | First operand source: 0 register file, 1 memory-stage result, 2 writeback result |
| byp_sel2 | output | 2 | Second operand source, same encoding |
| pc_hold | output | 1 | Keep the program counter |
| fd_hold | output | 1 | Keep the fetch/decode register |
| de_bubble | output | 1 | Load a no-op into the decode/execute register |
| fd_flush | output | 1 | Discard the fetch/decode register contents |
| de_flush | output | 1 | Discard the decode/execute register contents |

## Verification
On every cycle, the embedded properties check several rules. The memory-stage source beats the writeback source when both match. Register 0 is never bypassed. A stall occurs only behind a valid load. A redirect always squashes both younger stages and suppresses any stall. Two bubbles never occur back to back. Other behaviour can only be shown by the bench's scripted instruction streams, which run through a behavioural pipeline model: the total cycle count of each stream against its expected stall and flush totals, and the operand value that actually reaches execute against the value of the latest older writer.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output fwd_sel_e      sel
);
  logic src_live;
  logic mem_hit;
  logic wb_hit;

  assign src_live = src_used && (src != '0);
  assign mem_hit  = src_live && mem_wr && (mem_rd == src);
  assign wb_hit   = src_live && wb_wr && (wb_rd == src);

  // younger producer first
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  AST_NO_BYPASS_R0: assert property (@(posedge clk) disable iff (rst)
    (sel != FWD_RF) |-> (src != '0)); // R5
  AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (rst)
    (src_used && (src != '0) && mem_wr && wb_wr && (mem_rd == src) && (wb_rd == src))
      |-> (sel == FWD_MEM)); // R4
  AST_WB_HAS_WRITER: assert property (@(posedge clk) disable iff (rst)
    (sel == FWD_WB) |-> (wb_wr && (wb_rd == src) && src_used)); // R3
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSRC-1:0][AW-1:0]   id_src,
  input  logic [NSRC-1:0]           id_used,
  input  logic [AW-1:0]             ex_rd,
  input  logic                      ex_wen,
  input  logic                      ex_is_load,
  input  logic                      ex_valid,
  output logic                      hazard
);
  logic            producer;
  logic [NSRC-1:0] hit;

  assign producer = ex_valid && ex_is_load && ex_wen && (ex_rd != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = id_used[g] && (id_src[g] == ex_rd);
  end

  assign hazard = producer && (|hit);

  AST_STALL_BEHIND_LOAD: assert property (@(posedge clk) disable iff (rst)
    hazard |-> (ex_valid && ex_is_load && ex_wen)); // R6
  AST_STALL_NOT_R0: assert property (@(posedge clk) disable iff (rst)
    hazard |-> (ex_rd != '0)); // R5
endmodule

// File: rtl/hzd_seq_ctrl.sv
module hzd_seq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic load_use,
  input  logic redirect,
  output logic pc_hold,
  output logic fd_hold,
  output logic de_bubble,
  output logic fd_flush,
  output logic de_flush
);
  logic stall_go;

  // a redirect squashes the waiting consumer anyway, so it outranks the stall
  assign stall_go  = load_use && !redirect;
  assign pc_hold   = stall_go;
  assign fd_hold   = stall_go;
  assign de_bubble = stall_go;
  assign fd_flush  = redirect;
  assign de_flush  = redirect;

  AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (!pc_hold && !fd_hold && !de_bubble)); // R8
  AST_FLUSH_BOTH: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (fd_flush && de_flush)); // R7
  AST_ONE_INSERT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({de_bubble, de_flush})); // R8
  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    de_bubble |=> !de_bubble); // R6
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] dec_src1,
  input  logic [REG_AW-1:0] dec_src2,
  input  logic              dec_use1,
  input  logic              dec_use2,
  input  logic [REG_AW-1:0] exe_src1,
  input  logic [REG_AW-1:0] exe_src2,
  input  logic              exe_use1,
  input  logic              exe_use2,
  input  logic [REG_AW-1:0] exe_dst,
  input  logic              exe_wen,
  input  logic              exe_load,
  input  logic              exe_valid,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic              mem_valid,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  input  logic              wb_valid,
  input  logic              exe_redirect,
  output logic [1:0]        byp_sel1,
  output logic [1:0]        byp_sel2,
  output logic              pc_hold,
  output logic              fd_hold,
  output logic              de_bubble,
  output logic              fd_flush,
  output logic              de_flush
);
  localparam int NSRC = hzd_pkg::NUM_SRC;

  logic [NSRC-1:0][REG_AW-1:0] id_src;
  logic [NSRC-1:0][REG_AW-1:0] ex_src;
  logic [NSRC-1:0]             id_used;
  logic [NSRC-1:0]             ex_used;
  logic                        mem_wr;
  logic                        wb_wr;
  logic                        load_use;
  hzd_pkg::fwd_sel_e           ex_sel [NSRC];

  assign id_src  = {dec_src2, dec_src1};
  assign id_used = {dec_use2, dec_use1};
  assign ex_src  = {exe_src2, exe_src1};
  assign ex_used = {exe_use2, exe_use1};
  assign mem_wr  = mem_valid && mem_wen;
  assign wb_wr   = wb_valid && wb_wen;

  for (genvar g = 0; g < NSRC; g++) begin : g_pick
    hzd_fwd_pick #(.AW(REG_AW)) u_pick (
      .clk      (clk),
      .rst      (rst),
      .src      (ex_src[g]),
      .src_used (ex_used[g]),
      .mem_rd   (mem_dst),
      .mem_wr   (mem_wr),
      .wb_rd    (wb_dst),
      .wb_wr    (wb_wr),
      .sel      (ex_sel[g])
    );
  end

  assign byp_sel1 = ex_sel[0];
  assign byp_sel2 = ex_sel[1];

  hzd_loaduse #(.AW(REG_AW), .NSRC(NSRC)) u_loaduse (
    .clk        (clk),
    .rst        (rst),
    .id_src     (id_src),
    .id_used    (id_used),
    .ex_rd      (exe_dst),
    .ex_wen     (exe_wen),
    .ex_is_load (exe_load),
    .ex_valid   (exe_valid),
    .hazard     (load_use)
  );

  hzd_seq_ctrl u_seq (
    .clk       (clk),
    .rst       (rst),
    .load_use  (load_use),
    .redirect  (exe_redirect),
    .pc_hold   (pc_hold),
    .fd_hold   (fd_hold),
    .de_bubble (de_bubble),
    .fd_flush  (fd_flush),
    .de_flush  (de_flush)
  );

  AST_INVALID_MEM_NO_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (!mem_valid || !mem_wen) |-> ((byp_sel1 != 2'd1) && (byp_sel2 != 2'd1))); // R5
  AST_MEM_BYPASS_SRC: assert property (@(posedge clk) disable iff (rst)
    (byp_sel1 == 2'd1) |-> (exe_use1 && (exe_src1 == mem_dst))); // R2
endmodule

// File: tb/hzd_unit_tb.sv
`timescale 1ns/1ps
module hzd_unit_tb;
  localparam int AW       = 5;
  localparam int HALF     = 10;   // 20 ns period, 50 MHz
  localparam int MAXI     = 16;
  localparam int WD_LIMIT = 20000;

  typedef struct packed {
    logic [AW-1:0] d1, d2; logic du1, du2;
    logic [AW-1:0] e1, e2; logic eu1, eu2;
    logic [AW-1:0] edst; logic ewen, eld, evld;
    logic [AW-1:0] mdst; logic mwen, mvld;
    logic [AW-1:0] wdst; logic wwen, wvld;
    logic redir;
  } stim_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic direct = 1'b1;
  always #HALF clk = ~clk;

  stim_t d_stim = '0;
  stim_t m_stim, s;
  always_comb s = direct ? d_stim : m_stim;

  logic [1:0] byp_sel1, byp_sel2;
  logic pc_hold, fd_hold, de_bubble, fd_flush, de_flush;

  hzd_unit #(.REG_AW(AW)) u_dut (
    .clk(clk), .rst(rst),
    .dec_src1(s.d1), .dec_src2(s.d2), .dec_use1(s.du1), .dec_use2(s.du2),
    .exe_src1(s.e1), .exe_src2(s.e2), .exe_use1(s.eu1), .exe_use2(s.eu2),
    .exe_dst(s.edst), .exe_wen(s.ewen), .exe_load(s.eld), .exe_valid(s.evld),
    .mem_dst(s.mdst), .mem_wen(s.mwen), .mem_valid(s.mvld),
    .wb_dst(s.wdst), .wb_wen(s.wwen), .wb_valid(s.wvld),
    .exe_redirect(s.redir),
    .byp_sel1(byp_sel1), .byp_sel2(byp_sel2), .pc_hold(pc_hold), .fd_hold(fd_hold),
    .de_bubble(de_bubble), .fd_flush(fd_flush), .de_flush(de_flush)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- scripted instruction streams ----------------
  logic [AW-1:0] s_rd [MAXI];
  logic [AW-1:0] s_r1 [MAXI];
  logic [AW-1:0] s_r2 [MAXI];
  logic          s_ld [MAXI];
  logic          s_br [MAXI];
  int            n_instr = 0;

  logic       fd_v, de_v, em_v, mw_v;
  logic [7:0] fd_i, de_i, em_i, mw_i, pc;
  logic [15:0] rf [32];
  int cyc, wb_cnt, last_cyc;

  always_comb begin
    m_stim      = '0;
    m_stim.d1   = s_r1[fd_i];  m_stim.d2 = s_r2[fd_i];
    m_stim.du1  = fd_v;        m_stim.du2 = fd_v;
    m_stim.e1   = s_r1[de_i];  m_stim.e2 = s_r2[de_i];
    m_stim.eu1  = de_v;        m_stim.eu2 = de_v;
    m_stim.edst = s_rd[de_i];  m_stim.ewen = 1'b1;
    m_stim.eld  = s_ld[de_i];  m_stim.evld = de_v;
    m_stim.mdst = s_rd[em_i];  m_stim.mwen = 1'b1; m_stim.mvld = em_v;
    m_stim.wdst = s_rd[mw_i];  m_stim.wwen = 1'b1; m_stim.wvld = mw_v;
    m_stim.redir = de_v && s_br[de_i];
  end

  // behavioural pipeline registers steered by the unit's controls
  always @(posedge clk) begin
    if (rst || direct) begin
      fd_v <= 0; de_v <= 0; em_v <= 0; mw_v <= 0;
      fd_i <= 0; de_i <= 0; em_i <= 0; mw_i <= 0; pc <= 0;
      cyc <= 0; wb_cnt <= 0; last_cyc <= 0;
      for (int k = 0; k < 32; k++) rf[k] <= 16'd0;
    end else begin
      cyc <= cyc + 1;
      if (mw_v && s_rd[mw_i] != 0) rf[s_rd[mw_i]] <= 16'(mw_i) + 16'd100;
      mw_v <= em_v; mw_i <= em_i;
      em_v <= de_v; em_i <= de_i;
      if (de_flush || de_bubble) de_v <= 1'b0;
      else begin de_v <= fd_v; de_i <= fd_i; end
      if (fd_flush) begin
        fd_v <= 1'b0;
        pc   <= de_i + 8'd1;
      end else begin
        if (!pc_hold && int'(pc) < n_instr) pc <= pc + 8'd1;
        if (!fd_hold) begin
          if (int'(pc) < n_instr) begin fd_v <= 1'b1; fd_i <= pc; end
          else fd_v <= 1'b0;
        end
      end
      if (em_v) begin
        wb_cnt <= wb_cnt + 1;
        if (wb_cnt + 1 == n_instr) last_cyc <= cyc + 1;
      end
    end
  end

  // ---------------- scoreboard queues ----------------
  logic [8:0]  dq_exp [$];
  string       dq_req [$];
  logic [39:0] opq    [$];

  function automatic logic [15:0] op_val(input logic [1:0] sel, input logic [AW-1:0] rs);
    case (sel)
      2'd1:    return em_v ? (s_ld[em_i] ? 16'hDEAD : 16'(em_i) + 16'd100) : 16'hBAD0;
      2'd2:    return mw_v ? 16'(mw_i) + 16'd100 : 16'hBAD0;
      default: return rf[rs];
    endcase
  endfunction

  // monitor: a quarter period after the falling edge
  always @(negedge clk) begin
    #5;
    if (direct && dq_exp.size() > 0) begin
      logic [8:0] e;
      logic [8:0] g;
      string r;
      e = dq_exp.pop_front();
      r = dq_req.pop_front();
      g = {byp_sel1, byp_sel2, pc_hold, fd_hold, de_bubble, fd_flush, de_flush};
      check(g == e, r, "control vector", g, e);
    end else if (!direct && !rst && de_v) begin
      if (opq.size() == 0) check(1'b0, "R1", "unexpected instruction in execute", de_i, 0);
      else begin
        logic [39:0] it;
        logic [15:0] ga, gb;
        it = opq.pop_front();
        ga = op_val(byp_sel1, s_r1[de_i]);
        gb = op_val(byp_sel2, s_r2[de_i]);
        check(de_i == it[39:32], "R1", "program order in execute", de_i, it[39:32]);
        check(ga == it[31:16], "R2 R3 R4 R5", "operand 1 value", ga, it[31:16]);
        check(gb == it[15:0],  "R2 R3 R4 R5", "operand 2 value", gb, it[15:0]);
      end
    end
  end

  // ---------------- drivers ----------------
  task automatic vec(input stim_t st, input logic [8:0] exp, input string req);
    @(negedge clk);
    d_stim = st;
    dq_exp.push_back(exp);
    dq_req.push_back(req);
  endtask

  task automatic ins(input int i, input int rd, input int r1, input int r2,
                     input bit ld, input bit br);
    s_rd[i] = AW'(rd); s_r1[i] = AW'(r1); s_r2[i] = AW'(r2);
    s_ld[i] = ld; s_br[i] = br;
    if (i + 1 > n_instr) n_instr = i + 1;
  endtask

  function automatic logic [15:0] gold(input int i, input logic [AW-1:0] rs);
    if (rs == 0) return 16'd0;
    for (int j = i - 1; j >= 0; j--)
      if (s_rd[j] == rs) return 16'(j) + 16'd100;
    return 16'd0;
  endfunction

  task automatic run_script(input string req);
    int nl, nt, expc;
    rst = 1'b1;
    direct = 1'b0;
    opq.delete();
    nl = 0; nt = 0;
    for (int i = 0; i < n_instr; i++) begin
      opq.push_back({8'(i), gold(i, s_r1[i]), gold(i, s_r2[i])});
      if (s_br[i]) nt++;
      if (i > 0 && s_ld[i-1] && s_rd[i-1] != 0 &&
          (s_r1[i] == s_rd[i-1] || s_r2[i] == s_rd[i-1])) nl++;
    end
    expc = n_instr + 3 + nl + 2 * nt;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    while (wb_cnt != n_instr) @(negedge clk);
    @(negedge clk);
    #6;
    check(last_cyc == expc, req, "cycles to last writeback", last_cyc, expc);
    check(opq.size() == 0, req, "instructions left unchecked", opq.size(), 0);
    rst = 1'b1;
  endtask

  task automatic clear_script();
    for (int i = 0; i < MAXI; i++) begin
      s_rd[i] = '0; s_r1[i] = '0; s_r2[i] = '0; s_ld[i] = 0; s_br[i] = 0;
    end
    n_instr = 0;
  endtask

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > WD_LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", wd, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    stim_t st;
    clear_script();

    // R9: reset with idle inputs
    vec('0, 9'd0, "R9");
    @(negedge clk);
    rst = 1'b0;

    // R2: memory-stage match on operand 1
    st = '0; st.e1 = 5'd3; st.eu1 = 1; st.mdst = 5'd3; st.mwen = 1; st.mvld = 1;
    vec(st, 9'b01_00_00000, "R2");
    // R3: writeback-only match on operand 2
    st = '0; st.e2 = 5'd7; st.eu2 = 1; st.wdst = 5'd7; st.wwen = 1; st.wvld = 1;
    vec(st, 9'b00_10_00000, "R3");
    // R4: both stages match, memory stage wins
    st = '0; st.e1 = 5'd4; st.eu1 = 1; st.mdst = 5'd4; st.mwen = 1; st.mvld = 1;
    st.wdst = 5'd4; st.wwen = 1; st.wvld = 1;
    vec(st, 9'b01_00_00000, "R4");
    // R5: register 0 writer, and writer with write enable clear
    st = '0; st.eu1 = 1; st.mvld = 1; st.mwen = 1;
    st.e2 = 5'd9; st.eu2 = 1; st.wdst = 5'd9; st.wvld = 1; st.wwen = 0;
    vec(st, 9'd0, "R5");
    // R5: operand unused, and invalid memory stage
    st = '0; st.e1 = 5'd8; st.eu1 = 0; st.e2 = 5'd8; st.eu2 = 1;
    st.mdst = 5'd8; st.mwen = 1; st.mvld = 0;
    vec(st, 9'd0, "R5");
    // R6: load-use on the second decode source
    st = '0; st.edst = 5'd6; st.ewen = 1; st.eld = 1; st.evld = 1;
    st.d2 = 5'd6; st.du2 = 1;
    vec(st, 9'b00_00_11100, "R6");
    // R5: load into register 0 read by decode
    st = '0; st.edst = 5'd0; st.ewen = 1; st.eld = 1; st.evld = 1; st.d1 = 5'd0; st.du1 = 1;
    vec(st, 9'd0, "R5");
    // R5: matching load but execute stage invalid
    st = '0; st.edst = 5'd6; st.ewen = 1; st.eld = 1; st.evld = 0; st.d1 = 5'd6; st.du1 = 1;
    vec(st, 9'd0, "R5");
    // R7: redirect alone
    st = '0; st.redir = 1;
    vec(st, 9'b00_00_00011, "R7");
    // R8: redirect together with load-use
    st = '0; st.redir = 1; st.edst = 5'd2; st.ewen = 1; st.eld = 1; st.evld = 1;
    st.d1 = 5'd2; st.du1 = 1;
    vec(st, 9'b00_00_00011, "R8");
    vec('0, 9'd0, "R5");
    @(negedge clk);
    @(negedge clk);

    // R1: independent stream
    clear_script();
    for (int i = 0; i < 6; i++) ins(i, i + 1, 0, 0, 0, 0);
    run_script("R1");

    // R2 R3 R4: dependency chains without loads
    clear_script();
    ins(0, 5, 0, 0, 0, 0); ins(1, 5, 0, 0, 0, 0); ins(2, 6, 5, 5, 0, 0);
    ins(3, 7, 5, 6, 0, 0); ins(4, 8, 6, 5, 0, 0); ins(5, 9, 7, 8, 0, 0);
    run_script("R1 R2 R3 R4");

    // R6: load-use pairs and a load at distance two
    clear_script();
    ins(0, 4, 0, 0, 1, 0); ins(1, 5, 4, 0, 0, 0); ins(2, 6, 0, 0, 1, 0);
    ins(3, 7, 0, 0, 0, 0); ins(4, 8, 0, 6, 0, 0); ins(5, 9, 0, 0, 1, 0);
    ins(6, 10, 0, 9, 0, 0); ins(7, 11, 9, 10, 0, 0);
    run_script("R6");

    // R7: two redirecting branches, one followed by a load-use pair
    clear_script();
    ins(0, 1, 0, 0, 0, 0); ins(1, 0, 1, 0, 0, 1); ins(2, 2, 1, 0, 0, 0);
    ins(3, 3, 2, 0, 0, 0); ins(4, 0, 3, 0, 0, 1); ins(5, 4, 0, 0, 1, 0);
    ins(6, 5, 4, 4, 0, 0);
    run_script("R7");

    // R5: register 0 writers never bypass or stall
    clear_script();
    ins(0, 0, 0, 0, 0, 0); ins(1, 0, 0, 0, 1, 0); ins(2, 2, 0, 0, 0, 0);
    ins(3, 3, 2, 0, 0, 0); ins(4, 4, 0, 0, 0, 0);
    run_script("R5");

    // R6 R7: branch waiting on a load, then redirecting
    clear_script();
    ins(0, 3, 0, 0, 1, 0); ins(1, 0, 3, 0, 0, 1); ins(2, 4, 3, 0, 0, 0);
    run_script("R6 R7");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule